// File: doc/BRIEF.md
# Operand Source Selector with Register-File Read-Port Budget

This block sits in the rename/issue path of an out-of-order core. Each cycle it is offered a group of up to four micro-ops, each with up to two source logical registers and an optional destination. For every source it decides where the value will come from: the retired register file, a completed-but-unretired reorder-buffer entry, the result bus of a producer finishing this cycle, or nowhere yet because the producer is still executing. The answer comes from a location table that holds one state and one reorder-buffer tag per logical register. The table is updated by rename, completion and retirement.

The retired register file has only a few read ports, far fewer than the eight operands a full group can ask for. Sources that must come from the file are counted against that budget. A register read by several operands in the group costs one port. The block accepts the longest oldest-first run of micro-ops whose demand fits the budget, assigns port addresses, and raises a stall for the rest. Outputs are combinational on the current inputs and table contents. The table changes on the rising clock edge.

Top module: `operand_src_sel`

## Requirements
- R1: Only the leading run of valid slots starting at slot 0 is considered. A valid slot after an invalid one is ignored, and `acc_cnt` never counts past the first invalid slot.
- R2: After reset every logical register is in the retired file. A valid source then reports `src_sel` code 0 (register file).
- R3: Source codes are 0 = register file, 1 = reorder buffer, 2 = result bus, 3 = wait. A completed unretired producer gives 1 with its tag. An in-flight producer whose tag equals `cmp_tag` while `cmp_vld` is high gives 2 with that tag. Any other in-flight producer gives 3 with its tag.
- R4: Sources coded 1, 2 or 3 take no read port.
- R5: At most `RDPORTS` (default 2) read ports are used per cycle. Operands of accepted slots that read the same register-file register share one port.
- R6: `acc_cnt` is the longest oldest-first prefix of the valid run whose distinct register-file reads fit the port budget. `stall` is high exactly when that prefix is shorter than the valid run. If slot 0 alone does not fit, `acc_cnt` is 0.
- R7: A source whose register is the destination of an older slot in the same group gets code 3 and the tag of the youngest such slot. It takes no port.
- R8: An accepted slot with a destination marks that register in flight under its tag from the next cycle on. The youngest accepted writer wins. Held slots leave the table unchanged.
- R9: A retirement (`ret_vld`, `ret_tag`) returns to the register-file state only entries whose tag equals `ret_tag`. It takes effect in the same cycle's lookup.
- R10: A completion moves in-flight entries carrying `cmp_tag` to the reorder-buffer state from the next cycle.
- R11: A no-op slot (valid, no source valid, no destination valid) uses no port and changes no table entry, whatever its register fields hold.
- R12: Ports are filled from port 0 upward, in the order each distinct register-file register first appears. Operand index is slot*2+source. `src_port` gives the port of each register-file source. Unused ports have their enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | SLOTS | Slot valid, bit k = slot k (slot 0 oldest) |
| in_src_vld | input | SLOTS*SRCS | Source valid per operand, index slot*SRCS+source |
| in_src | input | SLOTS*SRCS*LW | Source logical register per operand |
| in_dst_vld | input | SLOTS | Destination valid per slot |
| in_dst | input | SLOTS*LW | Destination logical register per slot |
| in_tag | input | SLOTS*TAGW | Reorder-buffer tag given to each slot |
| cmp_vld | input | 1 | A producer completes this cycle |
| cmp_tag | input | TAGW | Tag of the completing producer |
| ret_vld | input | 1 | A producer retires this cycle |
| ret_tag | input | TAGW | Tag of the retiring producer |
| src_sel | output | SLOTS*SRCS*2 | Source code per operand (0 file, 1 ROB, 2 bus, 3 wait) |
| src_tag | output | SLOTS*SRCS*TAGW | Tag for codes 1 to 3 |
| src_port | output | SLOTS*SRCS*PW | Read port used by a code-0 operand |
| rp_en | output | RDPORTS | Read port enable |
| rp_addr | output | RDPORTS*LW | Read port register address |
| acc_cnt | output | CW | Number of slots accepted this cycle |
| stall | output | 1 | Some valid slots held back |

## Verification
The bench uses the default parameters: four slots, two sources, sixteen registers, 5-bit tags and a two-port budget. With only two ports, random groups that read up to six register-file registers overflow the budget often. The prefix cut therefore lands at every slot boundary, and port sharing between duplicate reads decides acceptance in many cycles. Because slot 0 has only two sources, a two-port budget can never reject slot 0, so an accept count of zero with a valid group cannot occur in this build. Random tag wrap-around and stale retirement tags exercise the tag-match rules for completion and retirement.

// File: rtl/opsel_pkg.sv
package opsel_pkg;

  // State of a logical register in the location table
  typedef enum logic [1:0] {
    LOC_RF  = 2'd0,
    LOC_ROB = 2'd1,
    LOC_FLT = 2'd2
  } loc_e;

  // Source code reported per operand
  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_ROB  = 2'd1,
    SRC_BYP  = 2'd2,
    SRC_WAIT = 2'd3
  } src_e;

endpackage

// File: rtl/opsel_loc_table.sv
module opsel_loc_table
  import opsel_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int LREGS = 16,
  parameter int TAGW  = 5,
  parameter int LW    = 4,
  parameter int CW    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ret_vld,
  input  logic [TAGW-1:0]            ret_tag,
  input  logic                       cmp_vld,
  input  logic [TAGW-1:0]            cmp_tag,
  input  logic [SLOTS-1:0]           dst_vld,
  input  logic [SLOTS-1:0][LW-1:0]   dst,
  input  logic [SLOTS-1:0][TAGW-1:0] dst_tag,
  input  logic [CW-1:0]              acc_cnt,
  output loc_e [LREGS-1:0]           eff_loc,
  output logic [LREGS-1:0][TAGW-1:0] eff_tag
);

  for (genvar r = 0; r < LREGS; r++) begin : g_ent
    loc_e            loc_q, loc_d;
    logic [TAGW-1:0] tag_q, tag_d;
    logic            ret_hit, cmp_hit, wr, upd;

    // retirement is seen by the lookup in the same cycle
    always_comb begin
      ret_hit = ret_vld && (loc_q != LOC_RF) && (tag_q == ret_tag);
      cmp_hit = cmp_vld && (loc_q == LOC_FLT) && (tag_q == cmp_tag);
    end

    assign eff_loc[r] = ret_hit ? LOC_RF : loc_q;
    assign eff_tag[r] = tag_q;

    // next state: youngest accepted writer, then retire, then complete
    always_comb begin
      wr    = 1'b0;
      tag_d = tag_q;
      loc_d = loc_q;
      for (int k = 0; k < SLOTS; k++) begin
        if ((CW'(k) < acc_cnt) && dst_vld[k] && (dst[k] == LW'(r))) begin
          wr    = 1'b1;
          tag_d = dst_tag[k];
        end
      end
      if (wr)           loc_d = LOC_FLT;
      else if (ret_hit) loc_d = LOC_RF;
      else if (cmp_hit) loc_d = LOC_ROB;
      upd = wr | ret_hit | cmp_hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        loc_q <= LOC_RF;
        tag_q <= '0;
      end else if (upd) begin
        loc_q <= loc_d;
        tag_q <= tag_d;
      end
    end
  end

endmodule

// File: rtl/opsel_resolve.sv
module opsel_resolve
  import opsel_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int SRCS  = 2,
  parameter int LREGS = 16,
  parameter int TAGW  = 5,
  parameter int LW    = 4,
  localparam int OPS  = SLOTS * SRCS
) (
  input  loc_e [LREGS-1:0]           eff_loc,
  input  logic [LREGS-1:0][TAGW-1:0] eff_tag,
  input  logic [OPS-1:0]             src_vld,
  input  logic [OPS-1:0][LW-1:0]     src,
  input  logic [SLOTS-1:0]           dst_vld,
  input  logic [SLOTS-1:0][LW-1:0]   dst,
  input  logic [SLOTS-1:0][TAGW-1:0] dst_tag,
  input  logic                       cmp_vld,
  input  logic [TAGW-1:0]            cmp_tag,
  output src_e [OPS-1:0]             sel,
  output logic [OPS-1:0][TAGW-1:0]   sel_tag,
  output logic [OPS-1:0]             need_rf
);

  for (genvar o = 0; o < OPS; o++) begin : g_op
    localparam int SL = o / SRCS;
    logic            grp;
    logic [TAGW-1:0] gtag;
    loc_e            loc;
    logic [TAGW-1:0] ltag;

    // youngest older writer inside the group
    always_comb begin
      grp  = 1'b0;
      gtag = '0;
      for (int j = 0; j < SL; j++) begin
        if (dst_vld[j] && (dst[j] == src[o])) begin
          grp  = 1'b1;
          gtag = dst_tag[j];
        end
      end
    end

    assign loc  = eff_loc[src[o]];
    assign ltag = eff_tag[src[o]];

    always_comb begin
      sel[o]     = SRC_RF;
      sel_tag[o] = '0;
      if (grp) begin
        sel[o]     = SRC_WAIT;
        sel_tag[o] = gtag;
      end else begin
        case (loc)
          LOC_ROB: begin
            sel[o]     = SRC_ROB;
            sel_tag[o] = ltag;
          end
          LOC_FLT: begin
            sel[o]     = (cmp_vld && (ltag == cmp_tag)) ? SRC_BYP : SRC_WAIT;
            sel_tag[o] = ltag;
          end
          default: sel[o] = SRC_RF;
        endcase
      end
    end

    assign need_rf[o] = src_vld[o] && !grp && (loc == LOC_RF);
  end

endmodule

// File: rtl/opsel_port_alloc.sv
module opsel_port_alloc #(
  parameter int SLOTS   = 4,
  parameter int SRCS    = 2,
  parameter int LW      = 4,
  parameter int RDPORTS = 2,
  parameter int PW      = 1,
  parameter int CW      = 3,
  localparam int OPS    = SLOTS * SRCS,
  localparam int RW     = $clog2(OPS + 1)
) (
  input  logic [SLOTS-1:0]           slot_vld,
  input  logic [OPS-1:0]             need_rf,
  input  logic [OPS-1:0][LW-1:0]     src,
  output logic [CW-1:0]              acc_cnt,
  output logic                       stall,
  output logic [OPS-1:0][PW-1:0]     op_port,
  output logic [RDPORTS-1:0]         rp_en,
  output logic [RDPORTS-1:0][LW-1:0] rp_addr
);

  logic [OPS-1:0]           first;
  logic [OPS-1:0][RW-1:0]   idx;
  logic [SLOTS-1:0][RW-1:0] dem;
  logic [RW-1:0]            cnt;
  logic [CW-1:0]            nreq;
  logic                     run_v, run_a;

  // first appearance of each register-file register and its port rank
  always_comb begin
    first = '0;
    idx   = '0;
    dem   = '0;
    cnt   = '0;
    for (int o = 0; o < OPS; o++) begin
      first[o] = need_rf[o];
      for (int j = 0; j < o; j++) begin
        if (need_rf[j] && (src[j] == src[o])) first[o] = 1'b0;
      end
      if (first[o]) begin
        idx[o] = cnt;
        cnt    = cnt + 1'b1;
      end else if (need_rf[o]) begin
        for (int j = 0; j < o; j++) begin
          if (first[j] && (src[j] == src[o])) idx[o] = idx[j];
        end
      end
      if ((o % SRCS) == SRCS - 1) dem[o/SRCS] = cnt;
    end
  end

  // oldest-first prefix that fits the port budget
  always_comb begin
    nreq    = '0;
    acc_cnt = '0;
    run_v   = 1'b1;
    run_a   = 1'b1;
    for (int k = 0; k < SLOTS; k++) begin
      if (!slot_vld[k]) run_v = 1'b0;
      if (run_v) nreq = nreq + 1'b1;
      if (!slot_vld[k] || (int'(dem[k]) > RDPORTS)) run_a = 1'b0;
      if (run_a) acc_cnt = acc_cnt + 1'b1;
    end
    stall = (acc_cnt != nreq);
  end

  always_comb begin
    for (int p = 0; p < RDPORTS; p++) begin
      rp_en[p]   = 1'b0;
      rp_addr[p] = '0;
      for (int o = 0; o < OPS; o++) begin
        if (first[o] && ((o / SRCS) < int'(acc_cnt)) && (int'(idx[o]) == p)) begin
          rp_en[p]   = 1'b1;
          rp_addr[p] = src[o];
        end
      end
    end
  end

  for (genvar o = 0; o < OPS; o++) begin : g_port
    assign op_port[o] = PW'(idx[o]);
  end

endmodule

// File: rtl/operand_src_sel.sv
module operand_src_sel
  import opsel_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int SRCS    = 2,
  parameter int LREGS   = 16,
  parameter int TAGW    = 5,
  parameter int RDPORTS = 2,
  localparam int LW     = $clog2(LREGS),
  localparam int OPS    = SLOTS * SRCS,
  localparam int PW     = (RDPORTS > 1) ? $clog2(RDPORTS) : 1,
  localparam int CW     = $clog2(SLOTS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SLOTS-1:0]        in_vld,
  input  logic [OPS-1:0]          in_src_vld,
  input  logic [OPS*LW-1:0]       in_src,
  input  logic [SLOTS-1:0]        in_dst_vld,
  input  logic [SLOTS*LW-1:0]     in_dst,
  input  logic [SLOTS*TAGW-1:0]   in_tag,
  input  logic                    cmp_vld,
  input  logic [TAGW-1:0]         cmp_tag,
  input  logic                    ret_vld,
  input  logic [TAGW-1:0]         ret_tag,
  output logic [OPS*2-1:0]        src_sel,
  output logic [OPS*TAGW-1:0]     src_tag,
  output logic [OPS*PW-1:0]       src_port,
  output logic [RDPORTS-1:0]      rp_en,
  output logic [RDPORTS*LW-1:0]   rp_addr,
  output logic [CW-1:0]           acc_cnt,
  output logic                    stall
);

  logic [OPS-1:0][LW-1:0]       src_a;
  logic [SLOTS-1:0][LW-1:0]     dst_a;
  logic [SLOTS-1:0][TAGW-1:0]   tag_a;
  loc_e [LREGS-1:0]             eff_loc;
  logic [LREGS-1:0][TAGW-1:0]   eff_tag;
  src_e [OPS-1:0]               sel_a;
  logic [OPS-1:0][TAGW-1:0]     stag_a;
  logic [OPS-1:0]               need_rf;
  logic [OPS-1:0][PW-1:0]       port_a;
  logic [RDPORTS-1:0][LW-1:0]   addr_a;

  for (genvar o = 0; o < OPS; o++) begin : g_opio
    assign src_a[o]               = in_src[o*LW +: LW];
    assign src_sel[o*2 +: 2]      = sel_a[o];
    assign src_tag[o*TAGW +: TAGW] = stag_a[o];
    assign src_port[o*PW +: PW]   = port_a[o];
  end

  for (genvar k = 0; k < SLOTS; k++) begin : g_slotio
    assign dst_a[k] = in_dst[k*LW +: LW];
    assign tag_a[k] = in_tag[k*TAGW +: TAGW];
  end

  for (genvar p = 0; p < RDPORTS; p++) begin : g_rpio
    assign rp_addr[p*LW +: LW] = addr_a[p];
  end

  opsel_loc_table #(
    .SLOTS(SLOTS), .LREGS(LREGS), .TAGW(TAGW), .LW(LW), .CW(CW)
  ) u_table (
    .clk     (clk),
    .rst_n   (rst_n),
    .ret_vld (ret_vld),
    .ret_tag (ret_tag),
    .cmp_vld (cmp_vld),
    .cmp_tag (cmp_tag),
    .dst_vld (in_dst_vld),
    .dst     (dst_a),
    .dst_tag (tag_a),
    .acc_cnt (acc_cnt),
    .eff_loc (eff_loc),
    .eff_tag (eff_tag)
  );

  opsel_resolve #(
    .SLOTS(SLOTS), .SRCS(SRCS), .LREGS(LREGS), .TAGW(TAGW), .LW(LW)
  ) u_resolve (
    .eff_loc (eff_loc),
    .eff_tag (eff_tag),
    .src_vld (in_src_vld),
    .src     (src_a),
    .dst_vld (in_dst_vld),
    .dst     (dst_a),
    .dst_tag (tag_a),
    .cmp_vld (cmp_vld),
    .cmp_tag (cmp_tag),
    .sel     (sel_a),
    .sel_tag (stag_a),
    .need_rf (need_rf)
  );

  opsel_port_alloc #(
    .SLOTS(SLOTS), .SRCS(SRCS), .LW(LW), .RDPORTS(RDPORTS), .PW(PW), .CW(CW)
  ) u_alloc (
    .slot_vld (in_vld),
    .need_rf  (need_rf),
    .src      (src_a),
    .acc_cnt  (acc_cnt),
    .stall    (stall),
    .op_port  (port_a),
    .rp_en    (rp_en),
    .rp_addr  (addr_a)
  );

endmodule

// File: rtl/opsel_chk.sv
module opsel_chk
  import opsel_pkg::*;
#(
  parameter int SLOTS   = 4,
  parameter int SRCS    = 2,
  parameter int TAGW    = 5,
  parameter int RDPORTS = 2,
  parameter int LW      = 4,
  parameter int PW      = 1,
  parameter int CW      = 3,
  localparam int OPS    = SLOTS * SRCS
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [SLOTS-1:0]      in_vld,
  input logic [OPS-1:0]        in_src_vld,
  input logic [OPS*LW-1:0]     in_src,
  input logic [SLOTS-1:0]      in_dst_vld,
  input logic [SLOTS*LW-1:0]   in_dst,
  input logic                  cmp_vld,
  input logic [TAGW-1:0]       cmp_tag,
  input logic                  ret_vld,
  input logic [OPS*2-1:0]      src_sel,
  input logic [OPS*TAGW-1:0]   src_tag,
  input logic [OPS*PW-1:0]     src_port,
  input logic [RDPORTS-1:0]    rp_en,
  input logic [RDPORTS*LW-1:0] rp_addr,
  input logic [CW-1:0]         acc_cnt,
  input logic                  stall
);

  // R6
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (int'(acc_cnt) < SLOTS));

  // R6
  held_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && (int'(acc_cnt) < SLOTS)) |-> in_vld[acc_cnt]);

  // R1
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && (int'(acc_cnt) < SLOTS)) |-> !in_vld[acc_cnt]);

  // R8
  rename_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past((acc_cnt != '0) && in_dst_vld[0] && in_vld[0]) && !ret_vld &&
     in_vld[0] && in_src_vld[0] && (in_src[LW-1:0] == $past(in_dst[LW-1:0])))
    |-> (src_sel[1:0] != SRC_RF));

  for (genvar p = 1; p < RDPORTS; p++) begin : g_fill
    // R12
    port_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rp_en[p] |-> rp_en[p-1]);
  end

  for (genvar o = 0; o < OPS; o++) begin : g_op
    localparam int SL = o / SRCS;
    // R3
    bypass_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_sel[o*2 +: 2] == SRC_BYP) |-> (cmp_vld && (src_tag[o*TAGW +: TAGW] == cmp_tag)));
    // R12
    port_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((SL < int'(acc_cnt)) && in_src_vld[o] && (src_sel[o*2 +: 2] == SRC_RF))
      |-> (rp_en[src_port[o*PW +: PW]] &&
           (rp_addr[src_port[o*PW +: PW]*LW +: LW] == in_src[o*LW +: LW])));
  end

endmodule

bind operand_src_sel opsel_chk #(
  .SLOTS(SLOTS), .SRCS(SRCS), .TAGW(TAGW), .RDPORTS(RDPORTS),
  .LW(LW), .PW(PW), .CW(CW)
) u_chk (.*);

// File: tb/sim_operand_src_sel.sv
module sim_operand_src_sel;

  localparam int NS = 4, NSRC = 2, NOPS = 8, NL = 16, TW = 5, NP = 2;
  localparam int LW = 4, PW = 1, CW = 3;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic [NS-1:0]              b_vld, b_dvld;
  logic [NOPS-1:0]            b_svld;
  logic [NOPS-1:0][LW-1:0]    b_src;
  logic [NS-1:0][LW-1:0]      b_dst;
  logic [NS-1:0][TW-1:0]      b_tag;
  logic                       b_cv, b_rv;
  logic [TW-1:0]              b_ct, b_rt;

  logic [NOPS-1:0][1:0]       o_sel;
  logic [NOPS-1:0][TW-1:0]    o_tag;
  logic [NOPS-1:0][PW-1:0]    o_port;
  logic [NP-1:0]              o_pen;
  logic [NP-1:0][LW-1:0]      o_paddr;
  logic [CW-1:0]              o_acc;
  logic                       o_stall;

  operand_src_sel u0 (
    .clk(clk), .rst_n(rst_n),
    .in_vld(b_vld), .in_src_vld(b_svld), .in_src(b_src),
    .in_dst_vld(b_dvld), .in_dst(b_dst), .in_tag(b_tag),
    .cmp_vld(b_cv), .cmp_tag(b_ct), .ret_vld(b_rv), .ret_tag(b_rt),
    .src_sel(o_sel), .src_tag(o_tag), .src_port(o_port),
    .rp_en(o_pen), .rp_addr(o_paddr), .acc_cnt(o_acc), .stall(o_stall)
  );

  // model: 0 file, 1 reorder buffer, 2 in flight
  int ms[NL], mt[NL], es[NL], et[NL];
  int e_sel[NOPS], e_tag[NOPS], e_port[NOPS], e_need[NOPS];
  int plist[NOPS];
  int pcnt, e_acc, e_nreq;
  int nchk = 0, nfail = 0;
  int next_tag = 0;
  bit done = 1'b0;

  task automatic chk(string req, int act, int exp, string what);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic model_eval();
    bit run;
    int newc;
    int tmp[NSRC];
    for (int r = 0; r < NL; r++) begin
      es[r] = ms[r];
      et[r] = mt[r];
      if (b_rv && ms[r] != 0 && mt[r] == int'(b_rt)) es[r] = 0;
    end
    e_nreq = 0;
    run = 1;
    for (int k = 0; k < NS; k++) begin
      if (!b_vld[k]) run = 0;
      if (run) e_nreq++;
    end
    pcnt = 0;
    e_acc = 0;
    run = 1;
    for (int k = 0; k < NS; k++) begin
      for (int s = 0; s < NSRC; s++) begin
        int o, lr, g;
        o = k * NSRC + s;
        e_sel[o] = 0; e_tag[o] = 0; e_port[o] = 0; e_need[o] = 0;
        if (b_svld[o]) begin
          lr = int'(b_src[o]);
          g = -1;
          for (int j = 0; j < k; j++)
            if (b_dvld[j] && b_dst[j] == b_src[o]) g = j;
          if (g >= 0) begin
            e_sel[o] = 3; e_tag[o] = int'(b_tag[g]);
          end else if (es[lr] == 0) begin
            e_need[o] = 1;
          end else if (es[lr] == 1) begin
            e_sel[o] = 1; e_tag[o] = et[lr];
          end else begin
            e_sel[o] = (b_cv && et[lr] == int'(b_ct)) ? 2 : 3;
            e_tag[o] = et[lr];
          end
        end
      end
      if (run && k < e_nreq) begin
        newc = 0;
        for (int s = 0; s < NSRC; s++) begin
          int o;
          bit seen;
          o = k * NSRC + s;
          if (e_need[o]) begin
            seen = 0;
            for (int i = 0; i < pcnt; i++) if (plist[i] == int'(b_src[o])) seen = 1;
            for (int i = 0; i < newc; i++) if (tmp[i] == int'(b_src[o])) seen = 1;
            if (!seen) begin tmp[newc] = int'(b_src[o]); newc++; end
          end
        end
        if (pcnt + newc <= NP) begin
          for (int i = 0; i < newc; i++) begin plist[pcnt] = tmp[i]; pcnt++; end
          e_acc++;
        end else run = 0;
      end else run = 0;
    end
    for (int o = 0; o < NOPS; o++)
      if (e_need[o] && (o / NSRC) < e_acc)
        for (int i = 0; i < pcnt; i++) if (plist[i] == int'(b_src[o])) e_port[o] = i;
  endtask

  task automatic model_commit();
    for (int r = 0; r < NL; r++) begin
      ms[r] = es[r];
      mt[r] = et[r];
      if (es[r] == 2 && b_cv && et[r] == int'(b_ct)) ms[r] = 1;
    end
    for (int k = 0; k < e_acc; k++)
      if (b_dvld[k]) begin ms[int'(b_dst[k])] = 2; mt[int'(b_dst[k])] = int'(b_tag[k]); end
  endtask

  task automatic compare(string lab);
    string la, ls, lp;
    la = (lab == "") ? "R6" : lab;
    ls = (lab == "") ? "R3" : lab;
    lp = (lab == "") ? "R12" : lab;
    chk(la, int'(o_acc), e_acc, "acc_cnt");
    chk(la, int'(o_stall), int'(e_acc < e_nreq), "stall");
    for (int p = 0; p < NP; p++) begin
      chk(lp, int'(o_pen[p]), int'(p < pcnt), $sformatf("rp_en[%0d]", p));
      if (p < pcnt) chk(lp, int'(o_paddr[p]), plist[p], $sformatf("rp_addr[%0d]", p));
    end
    for (int o = 0; o < NOPS; o++) begin
      if ((o / NSRC) < e_acc && b_svld[o]) begin
        chk(ls, int'(o_sel[o]), e_sel[o], $sformatf("src_sel[%0d]", o));
        if (e_sel[o] != 0) chk(ls, int'(o_tag[o]), e_tag[o], $sformatf("src_tag[%0d]", o));
        else chk(lp, int'(o_port[o]), e_port[o], $sformatf("src_port[%0d]", o));
      end
    end
  endtask

  // entry: posedge+1 with inputs driven; exit: next posedge+1
  task automatic cycle(string lab);
    #3;
    model_eval();
    compare(lab);
    model_commit();
    @(posedge clk);
    #1;
  endtask

  task automatic clr();
    b_vld = '0; b_dvld = '0; b_svld = '0; b_src = '0; b_dst = '0; b_tag = '0;
    b_cv = 0; b_rv = 0; b_ct = '0; b_rt = '0;
  endtask

  task automatic gen();
    int n, st, r;
    n = $urandom_range(0, 4);
    b_vld = NS'((1 << n) - 1);
    if ($urandom % 8 == 0) b_vld = b_vld | 4'b1000;
    for (int o = 0; o < NOPS; o++) begin
      b_svld[o] = ($urandom % 4) != 0;
      b_src[o]  = ($urandom % 3 != 0) ? LW'($urandom % 6) : LW'($urandom);
    end
    for (int k = 0; k < NS; k++) begin
      b_dvld[k] = 1'($urandom % 2);
      b_dst[k]  = LW'($urandom % 8);
      b_tag[k]  = TW'(next_tag);
      next_tag++;
    end
    b_cv = 0; b_ct = '0;
    if ($urandom % 2) begin
      st = $urandom % NL;
      for (int i = 0; i < NL; i++) begin
        r = (st + i) % NL;
        if (!b_cv && ms[r] == 2) begin b_cv = 1; b_ct = TW'(mt[r]); end
      end
    end
    b_rv = 0; b_rt = '0;
    if ($urandom % 10 == 0) begin
      b_rv = 1; b_rt = TW'($urandom);
    end else if ($urandom % 5 < 2) begin
      st = $urandom % NL;
      for (int i = 0; i < NL; i++) begin
        r = (st + i) % NL;
        if (!b_rv && ms[r] == 1) begin b_rv = 1; b_rt = TW'(mt[r]); end
      end
    end
  endtask

  initial begin
    #(100000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    clr();
    rst_n = 1'b0;
    for (int r = 0; r < NL; r++) begin ms[r] = 0; mt[r] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk);
    #1;

    // R2: all registers in the file after reset
    clr(); b_vld = 4'b0001; b_svld[1:0] = 2'b11; b_src[0] = 1; b_src[1] = 2;
    cycle("R2");
    // R5: eight reads of one register share a port
    clr(); b_vld = 4'b1111; b_svld = 8'hFF;
    for (int o = 0; o < NOPS; o++) b_src[o] = 3;
    cycle("R5");
    // R6: slot 1 needs a third port
    clr(); b_vld = 4'b0011; b_svld = 8'b0000_0111; b_src[0] = 1; b_src[1] = 2; b_src[2] = 4;
    cycle("R6");
    // R7: slot 1 reads slot 0's destination
    clr(); b_vld = 4'b0011; b_dvld[0] = 1; b_dst[0] = 5; b_tag[0] = 9;
    b_svld[2] = 1; b_src[2] = 5;
    cycle("R7");
    // R8: register 5 now in flight under tag 9
    clr(); b_vld = 4'b0001; b_svld[0] = 1; b_src[0] = 5;
    cycle("R8");
    // R10: completing this cycle gives the bus
    clr(); b_vld = 4'b0001; b_svld[0] = 1; b_src[0] = 5; b_cv = 1; b_ct = 9;
    cycle("R10");
    // R4: reorder-buffer reads take no port
    clr(); b_vld = 4'b0011; b_svld = 8'b0000_1111;
    b_src[0] = 5; b_src[1] = 6; b_src[2] = 7; b_src[3] = 5;
    cycle("R4");
    // R9: stale tag ignored, matching tag returns to file same cycle
    clr(); b_vld = 4'b0001; b_svld[0] = 1; b_src[0] = 5; b_rv = 1; b_rt = 10;
    cycle("R9");
    clr(); b_vld = 4'b0001; b_svld[0] = 1; b_src[0] = 5; b_rv = 1; b_rt = 9;
    cycle("R9");
    // R11: no-op group with junk register fields
    clr(); b_vld = 4'b1111;
    for (int k = 0; k < NS; k++) begin b_dst[k] = 6; b_tag[k] = 3; end
    for (int o = 0; o < NOPS; o++) b_src[o] = 6;
    cycle("R11");
    clr(); b_vld = 4'b0001; b_svld[0] = 1; b_src[0] = 6;
    cycle("R11");
    // R8: a held slot does not rename
    clr(); b_vld = 4'b0111; b_svld = 8'b0000_0111; b_src[0] = 1; b_src[1] = 2; b_src[2] = 3;
    b_dvld[2] = 1; b_dst[2] = 9; b_tag[2] = 11;
    cycle("R8");
    clr(); b_vld = 4'b0001; b_svld[0] = 1; b_src[0] = 9;
    cycle("R8");
    // R1: gap in the valid run
    clr(); b_vld = 4'b0101; b_svld[0] = 1; b_src[0] = 1; b_svld[4] = 1; b_src[4] = 2;
    cycle("R1");
    // R12: port order follows first appearance
    clr(); b_vld = 4'b0011; b_svld = 8'b0000_1111;
    b_src[0] = 4; b_src[1] = 4; b_src[2] = 2; b_src[3] = 4;
    cycle("R12");

    for (int i = 0; i < 4000; i++) begin
      gen();
      cycle("");
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule